// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block turns a demodulated, hysteresis-cleaned carrier envelope into reader-to-tag frames. It passes the envelope through a synchronizer and finds its rising edges. It counts the enabled ticks between one rising edge and the next. Each interval is sorted into a one, a zero or an invalid symbol by two tolerance windows. A long interval encodes a one and a short interval encodes a zero.

Valid symbols are packed into a frame word, with the first bit received in the least significant position. Frames carry no delimiters. A frame ends when the envelope stays quiet longer than the longest legal symbol, or when an interval falls outside both windows. At that point the block presents the bit count and the data word for one cycle. Protocol handling above the frame level is left to the consumer.

With the default parameters the nominal one is 150 ticks, the nominal zero is 90 ticks, the tolerance is 20 ticks, the timer parks at 3000 ticks and a frame holds at most 31 bits.

Top module: `pulse_interval_decoder`

## Requirements
- R1: The interval of a rising edge is the number of cycles with `tick_i` high, counted from the cycle in which the previous rising edge was detected up to, but not including, the cycle of the current one. Every detected rising edge restarts this count. The envelope passes through two synchronizer flops before edge detection.
- R2: An interval strictly greater than 130 and strictly less than 170 ticks decodes as a 1 bit.
- R3: An interval strictly greater than 70 and strictly less than 110 ticks decodes as a 0 bit.
- R4: An interval in neither window ends an active frame at that edge. If `env_i` is first sampled high at clock edge E, `frame_valid_o` is high after edge E+2. While no frame is active, such an interval is ignored.
- R5: While a frame is active, 170 ticks without a rising edge end the frame. With a tick on every cycle and the last rise sampled at edge E, `frame_valid_o` is high after edge E+172.
- R6: The interval timer stops at 3000 ticks and holds that value until the next rising edge. An edge after a longer quiet period is therefore invalid and never aliases onto a bit window.
- R7: Bit k of a frame, counting from 0, appears at `frame_data_o[k]`. Data positions at or above the bit count are 0.
- R8: A frame holds at most 31 bits. Later valid bits are dropped, and the count stays at 31.
- R9: `frame_valid_o` is a single-cycle pulse, raised only for a frame with at least one bit. `frame_bits_o` and `frame_data_o` are valid in that cycle.
- R10: Cycles with `tick_i` low add nothing to the interval or to the timeout count.
- R11: After reset, all outputs are 0 and the timer is parked, so the first rising edge never yields a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Envelope level, asynchronous to `clk` |
| tick_i | input | 1 | Time-base enable; one tick per high cycle |
| frame_valid_o | output | 1 | One-cycle pulse when a frame ends |
| frame_bits_o | output | 5 | Number of bits in the frame |
| frame_data_o | output | 31 | Frame bits, first received bit at bit 0 |

## Verification
The assertions watch, on every cycle:
- the timer restarting at each detected edge;
- the timer parking and holding at its limit;
- the timer freezing on cycles without a tick;
- the frame pulse being single-cycle and never empty;
- the bit count staying within its cap;
- data above the bit count staying clear.

Only the bench scenarios can show the decoding itself. It sweeps the interval across both window boundaries and surrounding values. It checks LSB-first packing under several patterns, frame end by an invalid interval and by timeout together with their exact latencies, truncation after 31 bits, a sparse tick enable, and an edge after a quiet period longer than the counter range.

// File: rtl/pid_pkg.sv
package pid_pkg;
    typedef enum logic [1:0] {
        SYM_BAD  = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2
    } sym_e;
endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[W-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/pid_classify.sv
module pid_classify
    import pid_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int ONE_NOM  = 150,
    parameter int ZERO_NOM = 90,
    parameter int TOL      = 20
) (
    input  logic [CNT_W-1:0] ivl_i,
    output sym_e             sym_o
);
    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_NOM - TOL);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_NOM + TOL);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_NOM - TOL);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_NOM + TOL);

    always_comb begin
        if (ivl_i > ONE_LO && ivl_i < ONE_HI)        sym_o = SYM_ONE;
        else if (ivl_i > ZERO_LO && ivl_i < ZERO_HI) sym_o = SYM_ZERO;
        else                                         sym_o = SYM_BAD;
    end
endmodule

// File: rtl/pulse_interval_decoder.sv
module pulse_interval_decoder
    import pid_pkg::*;
#(
    parameter int ONE_NOM    = 150,
    parameter int ZERO_NOM   = 90,
    parameter int TOL        = 20,
    parameter int PARK_TICKS = 3000,
    parameter int MAX_BITS   = 31,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(PARK_TICKS + 1),
    localparam int NB_W  = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                env_i,
    input  logic                tick_i,
    output logic                frame_valid_o,
    output logic [NB_W-1:0]     frame_bits_o,
    output logic [MAX_BITS-1:0] frame_data_o
);
    localparam logic [CNT_W-1:0] PARK_V    = CNT_W'(PARK_TICKS);
    localparam logic [CNT_W-1:0] TIMEOUT_V = CNT_W'(ONE_NOM + TOL);
    localparam logic [NB_W-1:0]  CAP_V     = NB_W'(MAX_BITS);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic                active;
        logic [NB_W-1:0]     nbits;
        logic [MAX_BITS-1:0] data;
        logic                fv;
        logic [NB_W-1:0]     out_n;
        logic [MAX_BITS-1:0] out_d;
    } st_t;

    st_t  st_d, st_q;
    logic rise;
    sym_e sym;
    logic end_frame;

    pid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (env_i),
        .rise_o (rise)
    );

    pid_classify #(
        .CNT_W    (CNT_W),
        .ONE_NOM  (ONE_NOM),
        .ZERO_NOM (ZERO_NOM),
        .TOL      (TOL)
    ) u_cls (
        .ivl_i (st_q.cnt),
        .sym_o (sym)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fv   = 1'b0;
        end_frame = 1'b0;
        if (rise) begin
            // the tick of the edge cycle belongs to the new interval
            st_d.cnt = CNT_W'(tick_i);
            if (sym == SYM_ONE || sym == SYM_ZERO) begin
                st_d.active = 1'b1;
                if (st_q.nbits < CAP_V) begin
                    st_d.data[st_q.nbits] = (sym == SYM_ONE);
                    st_d.nbits            = st_q.nbits + 1'b1;
                end
            end else if (st_q.active) begin
                end_frame = 1'b1;
            end
        end else begin
            if (tick_i && st_q.cnt != PARK_V) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.active && st_q.cnt >= TIMEOUT_V) end_frame = 1'b1;
        end
        if (end_frame) begin
            st_d.active = 1'b0;
            st_d.nbits  = '0;
            st_d.data   = '0;
            if (st_q.nbits != '0) begin
                st_d.fv    = 1'b1;
                st_d.out_n = st_q.nbits;
                st_d.out_d = st_q.data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= PARK_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid_o = st_q.fv;
    assign frame_bits_o  = st_q.out_n;
    assign frame_data_o  = st_q.out_d;
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
    parameter int CNT_W    = 12,
    parameter int NB_W     = 5,
    parameter int MAX_BITS = 31,
    parameter int PARK     = 3000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rise,
    input logic                tick,
    input logic [CNT_W-1:0]    cnt,
    input logic                fv,
    input logic [NB_W-1:0]     nbits,
    input logic [MAX_BITS-1:0] data
);
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt <= CNT_W'(1))); // R1
    AST_PARK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(PARK)); // R6
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(PARK) && !rise) |=> (cnt == CNT_W'(PARK))); // R6
    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !rise) |=> $stable(cnt)); // R10
    AST_PULSE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fv |-> (nbits != '0)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fv |=> !fv); // R9
    AST_BIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= NB_W'(MAX_BITS)); // R8
    AST_DATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fv |-> ((data >> nbits) == '0)); // R7
endmodule

bind pulse_interval_decoder pid_checker #(
    .CNT_W    (CNT_W),
    .NB_W     (NB_W),
    .MAX_BITS (MAX_BITS),
    .PARK     (PARK_TICKS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (rise),
    .tick  (tick_i),
    .cnt   (st_q.cnt),
    .fv    (frame_valid_o),
    .nbits (frame_bits_o),
    .data  (frame_data_o)
);

// File: tb/sim_pulse_interval_decoder.sv
module sim_pulse_interval_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env = 1'b0;
    logic        tick = 1'b1;
    logic        tick_alt = 1'b0;
    logic        fv;
    logic [4:0]  nb;
    logic [30:0] dat;

    int checks = 0;
    int errors = 0;
    int pcyc = 0;
    int last_drive = 0;
    int fr_tot = 0;
    int consec = 0;
    logic prev_fv = 1'b0;
    int          fr_n [0:63];
    logic [30:0] fr_d [0:63];
    int          fr_c [0:63];
    logic wd = 1'b0;

    always #4 clk = ~clk;

    pulse_interval_decoder u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .env_i         (env),
        .tick_i        (tick),
        .frame_valid_o (fv),
        .frame_bits_o  (nb),
        .frame_data_o  (dat)
    );

    always @(posedge clk) pcyc <= pcyc + 1;

    always @(negedge clk) begin
        tick <= tick_alt ? ~tick : 1'b1;
        if (fv) begin
            fr_n[fr_tot % 64] <= int'(nb);
            fr_d[fr_tot % 64] <= dat;
            fr_c[fr_tot % 64] <= pcyc;
            fr_tot <= fr_tot + 1;
            if (prev_fv) consec <= consec + 1;
        end
        prev_fv <= fv;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge_after(input int n);
        @(negedge clk) env = 1'b0;
        repeat (n - 1) @(negedge clk);
        env = 1'b1;
        last_drive = pcyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [63:0] bits, input int k,
                             input int p1, input int p0, input int gap, input string tag);
        int base;
        int en;
        logic [30:0] ed;
        base = fr_tot;
        edge_after(gap);
        for (int i = 0; i < k; i++) edge_after(bits[i] ? p1 : p0);
        idle(gap);
        en = (k > 31) ? 31 : k;
        ed = '0;
        for (int i = 0; i < en; i++) ed[i] = bits[i];
        chk(fr_tot == base + 1, {tag, " frame count"}, fr_tot - base, 1);
        chk(fr_n[base % 64] == en, {tag, " bit count"}, fr_n[base % 64], en);
        chk(fr_d[base % 64] == ed, {tag, " data"}, fr_d[base % 64], ed);
    endtask

    task automatic run_all();
        int base;
        idle(3);
        // R11 reset state
        chk(fv == 1'b0, "R11 valid after reset", fv, 0);
        chk(nb == 5'd0, "R11 count after reset", nb, 0);
        chk(dat == '0, "R11 data after reset", dat, 0);
        rst_n = 1'b1;
        // R11: first edge after reset is not a bit (timer parked)
        base = fr_tot;
        edge_after(150);
        edge_after(150);
        idle(400);
        chk(fr_tot == base + 1, "R11 frames after first edges", fr_tot - base, 1);
        chk(fr_n[base % 64] == 1, "R11 first edge ignored", fr_n[base % 64], 1);

        // R2 R3 R4 R1: sweep of single intervals across both windows
        for (int iv = 60; iv <= 180; iv++) begin
            int  exp_n;
            logic exp_b;
            base = fr_tot;
            edge_after(600);
            edge_after(iv);
            idle(400);
            exp_b = (iv > 130 && iv < 170);
            exp_n = (exp_b || (iv > 70 && iv < 110)) ? 1 : 0;
            chk(fr_tot - base == exp_n, "R2 R3 sweep frame presence", iv, exp_n);
            if (exp_n == 1 && fr_tot - base == 1)
                chk(fr_d[base % 64][0] == exp_b, "R2 R3 sweep bit value", iv, exp_b);
        end

        // R7 packing under several patterns and window extremes
        run_frame(64'hA5, 8, 150, 90, 600, "R7 pattern A5");
        run_frame(64'h3C96, 16, 131, 109, 600, "R7 pattern 3C96 edges");
        run_frame(64'h5A5A1234, 31, 169, 71, 600, "R7 pattern full 31");
        // R8 overflow
        run_frame(64'hDEADBEEF12345678, 40, 160, 80, 600, "R8 overflow 40 bits");

        // R4 invalid ends frame, then R5 timeout on the next one
        base = fr_tot;
        edge_after(600);
        edge_after(150); edge_after(90); edge_after(150); edge_after(150); edge_after(90);
        edge_after(120);
        idle(10);
        chk(fr_tot == base + 1, "R4 invalid ends frame", fr_tot - base, 1);
        chk(fr_c[base % 64] - last_drive == 3, "R4 end latency", fr_c[base % 64] - last_drive, 3);
        chk(fr_n[base % 64] == 5 && fr_d[base % 64] == 31'h0D, "R4 first frame content",
            fr_d[base % 64], 31'h0D);
        edge_after(90); edge_after(150); edge_after(150);
        idle(400);
        chk(fr_tot == base + 2, "R5 second frame by timeout", fr_tot - base, 2);
        chk(fr_n[(base + 1) % 64] == 3 && fr_d[(base + 1) % 64] == 31'h6, "R5 second frame content",
            fr_d[(base + 1) % 64], 31'h6);
        chk(fr_c[(base + 1) % 64] - last_drive == 173, "R5 timeout latency",
            fr_c[(base + 1) % 64] - last_drive, 173);

        // R6 park: quiet period beyond counter range must not alias to a 1
        base = fr_tot;
        edge_after(600);
        edge_after(4096 + 150);
        idle(400);
        chk(fr_tot == base, "R6 parked timer no alias", fr_tot - base, 0);

        // R10 sparse ticks: every other cycle
        tick_alt = 1'b1;
        idle(2);
        run_frame(64'h0D, 4, 300, 180, 1200, "R10 half-rate ticks");
        tick_alt = 1'b0;
        idle(4);

        // R9 pulse shape
        chk(consec == 0, "R9 single-cycle pulse", consec, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule